// File: doc/BRIEF.md
# Battery-Backed Power-Up Sequencer

This block governs oscillator start-up and first-power initialisation in a timekeeping device fed by a main supply and a backup battery. When only the battery is attached after a total loss of power, the oscillator is held off to save charge. It stays off until the main supply crosses the power-fail threshold or a valid serial address match arrives. That wake event starts the oscillator, issues a one-cycle load of default calendar values and starts a wake delay measured in timebase ticks. At the end of the delay the first temperature-conversion start strobe is issued.

After the first conversion, strobes repeat at a fixed tick interval for as long as either supply is valid. An oscillator-disable control bit stops the oscillator for data retention. While it is set, the tick counter is frozen and resumes from where it stopped. A registered supply-select output picks the main supply whenever it is above the power-fail threshold or above the battery.

The block uses one clock domain. A synchronous active-low reset stands for a complete loss of power. The loss of both supplies while the block is running has the same effect: it returns to the cold state and arms the calendar load again.

Top module: `pwrup_seq`

## Requirements
- R1: After a cold start, oscEn stays 0 until a cycle in which a supply is valid (mainGood or batPresent is 1) and a wake request is present (mainGood is 1 or addrMatch is 1). Ticks and address matches received while no supply is valid cause no wake.
- R2: The first convStart is a one-cycle pulse in the cycle after the clock edge that samples the WAKE_TICKS-th tick counted from the wake event. No convStart occurs earlier.
- R3: After the first conversion, convStart pulses for one cycle after every CONV_TICKS-th counted tick and at no other time.
- R4: calLoad is a one-cycle pulse in the cycle after the wake edge. While calLoad is 1, calWord carries BCD default values in these fields: [7:0] second 00, [15:8] minute 00, [23:16] hour 00, [31:24] weekday 01, [39:32] day 01, [47:40] month 01, [55:48] year 00. While calLoad is 0, calWord is 0.
- R5: Once running, neither a later address match nor the main supply becoming good produces another calLoad.
- R6: oscEn is 0 in every cycle in which oscDisable is 1. Ticks during those cycles are not counted, and the count resumes from its frozen value when oscDisable returns to 0.
- R7: When mainGood and batPresent are both 0 at a clock edge, oscEn drops to 0 after that edge. The next wake event produces a calLoad again and restarts the WAKE_TICKS delay.
- R8: supplyMain equals mainGood OR mainAboveBat as sampled at the previous clock edge.
- R9: While rstN is 0 at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Synchronous active-low reset, models total power loss |
| mainGood | input | 1 | Main supply above power-fail threshold |
| mainAboveBat | input | 1 | Main supply above battery voltage |
| batPresent | input | 1 | Battery valid |
| addrMatch | input | 1 | One-cycle valid serial address match |
| oscDisable | input | 1 | 1 stops the oscillator (data retention) |
| tick | input | 1 | Timebase tick, one cycle wide |
| oscEn | output | 1 | Oscillator enable |
| convStart | output | 1 | Temperature-conversion start strobe |
| calLoad | output | 1 | One-cycle load of default calendar values |
| calWord | output | 56 | Default calendar fields in BCD, valid while calLoad is 1 |
| supplyMain | output | 1 | 1 selects main supply, 0 selects battery |

## Verification
The embedded properties check on every cycle that a start-up from cold only follows a wake request, that calLoad and convStart are single-cycle pulses that appear only after a wake or while running, and that the tick counter never passes the limit of its current phase. They also check that no conversion follows a cycle in which the oscillator was disabled. Only the bench scenarios can show the exact tick on which the first and the periodic conversions land, and that a frozen count resumes at the right position. The same holds for the absence of a second calendar load while running, the re-arming after both supplies are lost, and the full sweep of the supply-select truth table.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    ST_COLD = 2'd0,
    ST_WAKE = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic useWake;
    logic calLoad;
  } dpCtrl_t;

  localparam int CAL_W = 56;

  // year, month, day, weekday, hour, minute, second (BCD)
  localparam logic [CAL_W-1:0] CAL_DEFAULT =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

endpackage

// File: rtl/pwrup_ctrl.sv
module pwrup_ctrl
  import pwrup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    mainGood,
  input  logic    batPresent,
  input  logic    addrMatch,
  input  logic    oscDisable,
  input  logic    tick,
  input  logic    cntHit,
  output dpCtrl_t ctrlOut,
  output logic    oscEn,
  output logic    convStart
);

  seqState_t stateQ, stateD;
  logic calLoadQ, calLoadD;
  logic convQ, convD;
  logic cntClrD;
  logic anyValid, wakeReq, running;
  logic pastOk;

  assign anyValid = mainGood | batPresent;
  assign wakeReq  = mainGood | addrMatch;
  assign running  = (stateQ != ST_COLD);

  always_comb begin
    stateD   = stateQ;
    calLoadD = 1'b0;
    convD    = 1'b0;
    cntClrD  = 1'b0;
    case (stateQ)
      ST_COLD: begin
        if (anyValid && wakeReq) begin
          stateD   = ST_WAKE;
          calLoadD = 1'b1;
          cntClrD  = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cntHit) begin
          stateD = ST_RUN;
          convD  = 1'b1;
        end
      end
      ST_RUN: begin
        if (cntHit) convD = 1'b1;
      end
      default: begin
        stateD  = ST_COLD;
        cntClrD = 1'b1;
      end
    endcase
    // Both supplies gone: back to cold, calendar load armed again
    if (!anyValid) begin
      stateD   = ST_COLD;
      cntClrD  = 1'b1;
      convD    = 1'b0;
      calLoadD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_COLD;
      calLoadQ <= 1'b0;
      convQ    <= 1'b0;
      pastOk   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      calLoadQ <= calLoadD;
      convQ    <= convD;
      pastOk   <= 1'b1;
    end
  end

  assign ctrlOut.cntClr  = cntClrD;
  assign ctrlOut.cntEn   = running && anyValid && !oscDisable && tick;
  assign ctrlOut.useWake = (stateQ == ST_WAKE);
  assign ctrlOut.calLoad = calLoadQ;

  assign oscEn     = running && !oscDisable;
  assign convStart = convQ;

  // R1: leaving the cold state needs a wake request in the cycle before
  p_wake_needs_event_r1: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    ($past(stateQ) == ST_COLD && stateQ != ST_COLD) |-> $past(wakeReq));

  // R4: calendar load is single-cycle
  p_cal_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    calLoadQ |=> !calLoadQ);

  // R5: a calendar load only follows the cold state
  p_cal_from_cold_r5: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    calLoadQ |-> ($past(stateQ) == ST_COLD));

  // R3: conversions only come from a running sequencer
  p_conv_running_r3: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    convQ |-> ($past(stateQ) != ST_COLD));

  // R2: conversion strobe is single-cycle
  p_conv_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    convQ |=> !convQ);

endmodule

// File: rtl/pwrup_dp.sv
module pwrup_dp
  import pwrup_pkg::*;
#(
  parameter int WAKE_TICKS = 128,
  parameter int CONV_TICKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrlIn,
  input  logic             mainGood,
  input  logic             mainAboveBat,
  output logic             cntHit,
  output logic [CAL_W-1:0] calWord,
  output logic             supplyMain
);

  localparam int MAXT  = (WAKE_TICKS > CONV_TICKS) ? WAKE_TICKS : CONV_TICKS;
  localparam int CNT_W = (MAXT > 2) ? $clog2(MAXT) : 1;
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_TICKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limitLast;
  logic             selQ;

  assign limitLast = ctrlIn.useWake ? WAKE_LAST : CONV_LAST;
  assign cntHit    = ctrlIn.cntEn && (tickCnt == limitLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (ctrlIn.cntClr || cntHit) begin
      tickCnt <= '0;
    end else if (ctrlIn.cntEn) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= mainGood | mainAboveBat;
  end

  assign supplyMain = selQ;
  assign calWord    = ctrlIn.calLoad ? CAL_DEFAULT : '0;

  // R2: counter never passes the limit of the current phase
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= limitLast);

  // R2: parameters must give a counter of at least two states
  initial begin
    p_param_ok_r2: assert (WAKE_TICKS >= 2 && CONV_TICKS >= 2);
  end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int WAKE_TICKS = 128,
  parameter int CONV_TICKS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mainGood,
  input  logic        mainAboveBat,
  input  logic        batPresent,
  input  logic        addrMatch,
  input  logic        oscDisable,
  input  logic        tick,
  output logic        oscEn,
  output logic        convStart,
  output logic        calLoad,
  output logic [55:0] calWord,
  output logic        supplyMain
);

  dpCtrl_t ctrlBus;
  logic    cntHit;

  pwrup_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mainGood   (mainGood),
    .batPresent (batPresent),
    .addrMatch  (addrMatch),
    .oscDisable (oscDisable),
    .tick       (tick),
    .cntHit     (cntHit),
    .ctrlOut    (ctrlBus),
    .oscEn      (oscEn),
    .convStart  (convStart)
  );

  pwrup_dp #(
    .WAKE_TICKS (WAKE_TICKS),
    .CONV_TICKS (CONV_TICKS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlIn       (ctrlBus),
    .mainGood     (mainGood),
    .mainAboveBat (mainAboveBat),
    .cntHit       (cntHit),
    .calWord      (calWord),
    .supplyMain   (supplyMain)
  );

  assign calLoad = ctrlBus.calLoad;

  // R6: a disabled oscillator yields no conversion in the next cycle
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    oscDisable |=> !convStart);

  // R7: with no supply at all the oscillator is off after the edge
  p_lost_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!mainGood && !batPresent) |=> !oscEn);

endmodule

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;

  localparam int CLK_P = 10;
  localparam int WAKE  = 6;
  localparam int CONV  = 4;
  localparam logic [55:0] CAL_EXP =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic clk = 0;
  logic rstN, mainGood, mainAboveBat, batPresent, addrMatch, oscDisable, tick;
  logic oscEn, convStart, calLoad, supplyMain;
  logic [55:0] calWord;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwrup_seq #(.WAKE_TICKS(WAKE), .CONV_TICKS(CONV)) dut (
    .clk(clk), .rstN(rstN), .mainGood(mainGood), .mainAboveBat(mainAboveBat),
    .batPresent(batPresent), .addrMatch(addrMatch), .oscDisable(oscDisable),
    .tick(tick), .oscEn(oscEn), .convStart(convStart), .calLoad(calLoad),
    .calWord(calWord), .supplyMain(supplyMain)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one tick pulse, then a quiet cycle; checks convStart in both
  task automatic tickPair(input string req, input logic expConv);
    tick = 1; cyc();
    chk(req, convStart, expConv);
    tick = 0; cyc();
    chk(req, convStart, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; mainGood = 0; mainAboveBat = 0; batPresent = 0;
    addrMatch = 0; oscDisable = 0; tick = 0;
    repeat (3) cyc();
    // R9 reset state
    chk("R9 oscEn", oscEn, 0);
    chk("R9 convStart", convStart, 0);
    chk("R9 calLoad", calLoad, 0);
    chk("R9 calWord", calWord, 0);
    chk("R9 supplyMain", supplyMain, 0);
    rstN = 1;

    // R1: no supply, address match ignored
    addrMatch = 1; cyc(); addrMatch = 0;
    chk("R1 no supply osc", oscEn, 0);
    chk("R1 no supply load", calLoad, 0);

    // R1: battery only, ticks do not wake
    batPresent = 1;
    for (int i = 0; i < 10; i++) begin
      tickPair("R1 battery idle conv", 0);
      chk("R1 battery idle osc", oscEn, 0);
      chk("R1 battery idle load", calLoad, 0);
    end

    // R4: wake by address match
    addrMatch = 1; cyc(); addrMatch = 0;
    chk("R4 load pulse", calLoad, 1);
    chk("R4 cal word", calWord, CAL_EXP);
    chk("R1 osc on after wake", oscEn, 1);
    cyc();
    chk("R4 load single", calLoad, 0);
    chk("R4 word cleared", calWord, 0);

    // R2: first conversion after WAKE ticks
    for (int i = 1; i <= WAKE; i++) tickPair("R2 wake delay", i == WAKE);

    // R3: periodic conversions
    for (int i = 1; i <= 3*CONV; i++) tickPair("R3 period", (i % CONV) == 0);

    // R5: no second load while running
    mainGood = 1; addrMatch = 1; cyc(); addrMatch = 0;
    chk("R5 no reload", calLoad, 0);
    cyc();
    chk("R5 no reload late", calLoad, 0);
    chk("R5 still running", oscEn, 1);

    // R6: freeze mid-period
    tickPair("R6 pre", 0);
    tickPair("R6 pre", 0);
    oscDisable = 1; cyc();
    chk("R6 osc off", oscEn, 0);
    for (int i = 0; i < 10; i++) begin
      tickPair("R6 frozen conv", 0);
      chk("R6 frozen osc", oscEn, 0);
    end
    oscDisable = 0; cyc();
    chk("R6 osc back", oscEn, 1);
    for (int i = 1; i <= CONV-2; i++) tickPair("R6 resume", i == CONV-2);

    // R7: both supplies lost, then rewake by main supply
    mainGood = 0; batPresent = 0; cyc();
    chk("R7 osc off", oscEn, 0);
    for (int i = 0; i < 3; i++) tickPair("R7 lost conv", 0);
    mainGood = 1; cyc();
    chk("R7 reload", calLoad, 1);
    chk("R7 reload word", calWord, CAL_EXP);
    chk("R7 osc on", oscEn, 1);
    for (int i = 1; i <= WAKE; i++) tickPair("R7 delay restart", i == WAKE);

    // R8: supply select sweep
    for (int v = 0; v < 8; v++) begin
      batPresent = v[2]; mainGood = v[1]; mainAboveBat = v[0];
      cyc();
      chk("R8 supply select", supplyMain, (v[1] | v[0]));
    end

    // R9: reset mid-run
    mainGood = 1; batPresent = 1; cyc(); cyc();
    rstN = 0; cyc();
    chk("R9 mid osc", oscEn, 0);
    chk("R9 mid supply", supplyMain, 0);
    chk("R9 mid load", calLoad, 0);
    rstN = 1; cyc();
    chk("R4 load after reset", calLoad, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule